// File: doc/BRIEF.md
# Multichannel Serial Audio Input Packer

The block takes up to eight independent serial audio inputs. Each input has its own bit clock, frame sync and data line, and all of them are sampled in the system clock domain through plain synchronizers. Each channel has its own 3-bit format code, which selects I2S, left-justified or right-justified framing. A frame-sync period carries one 64-bit left/right pair. The block turns each 32-bit half-frame slot into one 32-bit word. That word holds a 28-bit payload (normally a 24-bit sample followed by 4 status bits), a half-frame flag and a 3-bit channel tag.

Completed words wait in a one-word holding register per channel. A round-robin arbiter moves them into one shared 8-deep FIFO. The FIFO head is steered to one of eight output streams, and the stream is chosen by the tag carried in the word. Because of the tag, interleaved channels can share the queue and still reach the right consumer. A channel whose clock and frame sync stay low never produces a word and costs no queue bandwidth.

Top module: `audio_in_packer`

## Requirements
- R1: Every output word is laid out as payload in bits [31:4], half-frame flag in bit 3 and source channel number in bits [2:0].
- R2: The half-frame flag is 0 for the left (first) half-frame and 1 for the right (second) half-frame, whatever the format.
- R3: Format code 000 (I2S): frame sync low marks the left half, the slot's first bit comes one bit clock after the frame-sync change, and the payload is the first 28 bits of the slot, first-received bit in bit 31.
- R4: Format code 001 (left-justified): frame sync high marks the left half, the first slot bit is sampled on the same bit clock as the frame-sync change, and the payload is the first 28 bits of the slot.
- R5: Format code 010 (right-justified): frame sync high marks the left half, slots are timed as in R4, and the payload is the last 28 bits of the 32-bit slot.
- R6: The format code of channel n sits in chanModes[3n+2:3n]. Codes 011 to 111 behave exactly like 000.
- R7: A channel whose bit clock and frame sync stay low produces no output word.
- R8: A slot cut short by a frame-sync change before its 32nd bit produces no word.
- R9: Words that several channels complete at the same time are all delivered through round-robin arbitration without loss or overflow.
- R10: With every output stream stalled, the shared FIFO holds 8 words and each channel's holding register holds a 9th, all delivered later in order.
- R11: A word completed while the channel's holding register is still occupied and not being accepted sets that channel's overflowFlag bit. The flag stays set until reset, and the newer word replaces the held one.
- R12: outValid[k] is high only when the FIFO head carries tag k. The head leaves the FIFO only when outReady of that tag is high, and until then it holds outWord steady.
- R13: During and right after reset no outValid or overflowFlag bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanModes | input | 24 | Per-channel 3-bit format codes, channel n at [3n+2:3n] |
| serBclk | input | 8 | Per-channel serial bit clock |
| serFs | input | 8 | Per-channel frame sync |
| serData | input | 8 | Per-channel serial data |
| outReady | input | 8 | Per-stream ready from the destinations |
| outValid | output | 8 | Per-stream valid, at most one set |
| outWord | output | 32 | Shared word bus for the selected stream |
| overflowFlag | output | 8 | Sticky per-channel holding-register overflow |

## Verification
The hardest state to reach is a holding-register overflow. It needs the shared FIFO full and the channel's held word stranded for a full 32-bit slot. The bench stalls every output stream and streams five back-to-back frames on one channel. The tenth word then lands on an occupied holding register, and the bench schedules the ninth word as lost in its expectations. While the stall lasts, it also raises ready on a stream that does not own the head to show that the head stays in place. It then releases the stall and checks that the surviving nine words drain in order.

// File: rtl/apk_pkg.sv
package apk_pkg;
  localparam int WORD_W    = 32;
  localparam int SLOT_BITS = 32;
  localparam int PAY_W     = 28;
  localparam int TAG_W     = 3;
  localparam int MODE_W    = 3;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2
  } fmt_e;

  // strobes from a channel's control to the shared datapath
  typedef struct packed {
    logic bitEn;    // synchronized bit-clock rising edge
    logic bitVal;   // data bit sampled at that edge
    logic emit;     // slot complete, capture a word
    logic side;     // half-frame flag of the completed slot
    logic rjAlign;  // take the last payload bits of the slot
  } chStrobe_t;

  function automatic fmt_e decodeMode(input logic [MODE_W-1:0] code);
    case (code)
      3'b001:  return FMT_LJ;
      3'b010:  return FMT_RJ;
      default: return FMT_I2S;
    endcase
  endfunction
endpackage

// File: rtl/apk_chan_ctrl.sv
module apk_chan_ctrl
  import apk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeCode,
  input  logic              bclkIn,
  input  logic              fsIn,
  input  logic              datIn,
  output chStrobe_t         strobe
);
  localparam int CNT_W = $clog2(SLOT_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SLOT_BITS - 1);

  logic [SYNC_STAGES:0]   bclkSync;
  logic [SYNC_STAGES-1:0] fsSync;
  logic [SYNC_STAGES-1:0] datSync;
  logic fsPrev, active, side;
  logic [CNT_W-1:0] bitCnt;
  fmt_e fmt;
  logic rise, fsNow, fsEdge, slotDone, newSide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkSync <= '0;
      fsSync   <= '0;
      datSync  <= '0;
    end else begin
      bclkSync <= {bclkSync[SYNC_STAGES-1:0], bclkIn};
      fsSync   <= {fsSync[SYNC_STAGES-2:0], fsIn};
      datSync  <= {datSync[SYNC_STAGES-2:0], datIn};
    end
  end

  assign fmt      = decodeMode(modeCode);
  assign rise     = bclkSync[SYNC_STAGES-1] & ~bclkSync[SYNC_STAGES];
  assign fsNow    = fsSync[SYNC_STAGES-1];
  assign fsEdge   = rise && (fsNow != fsPrev);
  assign slotDone = rise && active && (bitCnt == LAST_BIT);
  assign newSide  = (fmt == FMT_I2S) ? fsNow : ~fsNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsPrev <= 1'b0;
      active <= 1'b0;
      side   <= 1'b0;
      bitCnt <= '0;
    end else begin
      if (rise) fsPrev <= fsNow;
      if (fsEdge) begin
        active <= 1'b1;
        side   <= newSide;
        // I2S: the edge bit still belongs to the old slot
        bitCnt <= (fmt == FMT_I2S) ? '0 : CNT_W'(1);
      end else if (rise && active) begin
        if (slotDone) active <= 1'b0;
        else          bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign strobe.bitEn   = rise;
  assign strobe.bitVal  = datSync[SYNC_STAGES-1];
  assign strobe.emit    = slotDone;
  assign strobe.side    = side;
  assign strobe.rjAlign = (fmt == FMT_RJ);

  // R2: the half-frame flag only moves on a frame-sync change
  assert_side_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !fsEdge |=> $stable(side));
  // R8: a finished slot without a fresh edge leaves the channel idle
  assert_idle_after_slot_R8: assert property (@(posedge clk) disable iff (!rstN)
    (slotDone && !fsEdge) |=> !active);
endmodule

// File: rtl/apk_datapath.sv
module apk_datapath
  import apk_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  chStrobe_t         strobes [NUM_CH],
  input  logic [NUM_CH-1:0] outReady,
  output logic [NUM_CH-1:0] outValid,
  output logic [WORD_W-1:0] outWord,
  output logic [NUM_CH-1:0] overflowFlag
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [WORD_W-1:0] holdWord [NUM_CH];
  logic [NUM_CH-1:0] holdValid, grant, ovfBits;
  logic [IDX_W-1:0]  rrPtr, grantIdx;
  logic              doPush, doPop, fifoFull, fifoEmpty;
  logic [WORD_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W:0]    wrPtr, rdPtr, fifoLevel;
  logic [WORD_W-1:0] headWord;
  logic [IDX_W-1:0]  headIdx;

  // per-channel shifter and holding register
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [SLOT_BITS-2:0] shiftReg;
    logic [WORD_W-1:0]    nextShift, packedWord, holdQ;
    logic                 holdV, ovfQ;

    assign nextShift  = {shiftReg, strobes[ch].bitVal};
    assign packedWord = strobes[ch].rjAlign
      ? {nextShift[PAY_W-1:0], strobes[ch].side, TAG_W'(ch)}
      : {nextShift[WORD_W-1:WORD_W-PAY_W], strobes[ch].side, TAG_W'(ch)};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shiftReg <= '0;
        holdQ    <= '0;
        holdV    <= 1'b0;
        ovfQ     <= 1'b0;
      end else begin
        if (strobes[ch].bitEn) shiftReg <= nextShift[SLOT_BITS-2:0];
        if (strobes[ch].emit) begin
          holdQ <= packedWord;
          holdV <= 1'b1;
          if (holdV && !grant[ch]) ovfQ <= 1'b1;
        end else if (grant[ch]) begin
          holdV <= 1'b0;
        end
      end
    end

    assign holdWord[ch]  = holdQ;
    assign holdValid[ch] = holdV;
    assign ovfBits[ch]   = ovfQ;
  end

  // round-robin arbiter into the shared queue
  always_comb begin
    grant    = '0;
    grantIdx = rrPtr;
    doPush   = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (!doPush && !fifoFull && holdValid[(int'(rrPtr) + k) % NUM_CH]) begin
        doPush   = 1'b1;
        grantIdx = IDX_W'((int'(rrPtr) + k) % NUM_CH);
      end
    end
    if (doPush) grant[grantIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rrPtr <= '0;
    else if (doPush)
      rrPtr <= (grantIdx == IDX_W'(NUM_CH - 1)) ? '0 : grantIdx + 1'b1;
  end

  // shared FIFO
  assign fifoLevel = wrPtr - rdPtr;
  assign fifoEmpty = (wrPtr == rdPtr);
  assign fifoFull  = (wrPtr[PTR_W] != rdPtr[PTR_W]) &&
                     (wrPtr[PTR_W-1:0] == rdPtr[PTR_W-1:0]);
  assign headWord  = mem[rdPtr[PTR_W-1:0]];
  assign headIdx   = headWord[IDX_W-1:0];
  assign doPop     = !fifoEmpty && outReady[headIdx];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[PTR_W-1:0]] <= holdWord[grantIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  // tag-steered output streams
  for (genvar k = 0; k < NUM_CH; k++) begin : g_out
    assign outValid[k] = !fifoEmpty && (headIdx == IDX_W'(k));
  end
  assign outWord      = headWord;
  assign overflowFlag = ovfBits;

  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= (PTR_W+1)'(FIFO_DEPTH));
  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !doPop) |=> $stable(wrPtr));
  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((overflowFlag & $past(overflowFlag)) == $past(overflowFlag)));
  assert_outvalid_onehot_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outValid));
  assert_head_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((|outValid) && !(|(outValid & outReady))) |=> ($stable(outWord) && $stable(outValid)));
endmodule

// File: rtl/audio_in_packer.sv
module audio_in_packer
  import apk_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = MODE_W * NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  chanModes,
  input  logic [NUM_CH-1:0] serBclk,
  input  logic [NUM_CH-1:0] serFs,
  input  logic [NUM_CH-1:0] serData,
  input  logic [NUM_CH-1:0] outReady,
  output logic [NUM_CH-1:0] outValid,
  output logic [WORD_W-1:0] outWord,
  output logic [NUM_CH-1:0] overflowFlag
);
  chStrobe_t strobes [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ctrl
    apk_chan_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .modeCode (chanModes[MODE_W*ch +: MODE_W]),
      .bclkIn   (serBclk[ch]),
      .fsIn     (serFs[ch]),
      .datIn    (serData[ch]),
      .strobe   (strobes[ch])
    );
  end

  apk_datapath #(.NUM_CH(NUM_CH), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .outReady     (outReady),
    .outValid     (outValid),
    .outWord      (outWord),
    .overflowFlag (overflowFlag)
  );
endmodule

// File: tb/audio_in_packer_bench.sv
`timescale 1ns/1ps
module audio_in_packer_bench;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3*NCH-1:0] chanModes = '0;
  logic [NCH-1:0] serBclk = '0, serFs = '0, serData = '0, outReady = '1;
  logic [NCH-1:0] outValid, overflowFlag;
  logic [31:0] outWord;

  always #2.5 clk = ~clk;

  audio_in_packer u_audio_in_packer (
    .clk(clk), .rstN(rstN), .chanModes(chanModes), .serBclk(serBclk),
    .serFs(serFs), .serData(serData), .outReady(outReady),
    .outValid(outValid), .outWord(outWord), .overflowFlag(overflowFlag));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] expMem [NCH][64];
  int wrIdx [NCH];
  int rdIdx [NCH];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int ch, input int n, input int s);
    return 32'h1357_9BDF * (ch + 1) + 32'h0246_8ACE * n + (s ? 32'hF00D_0F0F : 32'h0);
  endfunction

  // expected word per requirement R1-style layout, pushed by the driver
  task automatic expect_word(input int ch, input logic [2:0] code, input logic [31:0] slot, input bit sd);
    logic [27:0] pay;
    pay = (code == 3'b010) ? slot[27:0] : slot[31:4];
    expMem[ch][wrIdx[ch]] = {pay, sd, 3'(ch)};
    wrIdx[ch]++;
  endtask

  task automatic drive_bit(input int ch, input logic f, input logic d);
    @(negedge clk);
    serFs[ch] = f; serData[ch] = d; serBclk[ch] = 1'b0;
    repeat (4) @(negedge clk);
    serBclk[ch] = 1'b1;
    repeat (4) @(negedge clk);
    serBclk[ch] = 1'b0;
  endtask

  task automatic send_frame(input int ch, input logic [31:0] lW, input logic [31:0] rW,
                            input bit expL, input bit expR);
    logic [2:0] code;
    bit i2sLike;
    code = chanModes[3*ch +: 3];
    i2sLike = (code != 3'b001) && (code != 3'b010);
    if (expL) expect_word(ch, code, lW, 1'b0);
    if (expR) expect_word(ch, code, rW, 1'b1);
    // short slots first: R8 says they yield nothing
    drive_bit(ch, 1'b1, 1'b1);
    drive_bit(ch, 1'b1, 1'b0);
    drive_bit(ch, 1'b0, 1'b1);
    for (int j = 0; j < 64; j++) begin
      logic f;
      f = i2sLike ? (((j + 1) % 64) >= 32) : (j < 32);
      drive_bit(ch, f, (j < 32) ? lW[31 - j] : rW[63 - j]);
    end
    @(negedge clk);
    serFs[ch] = 1'b0; serData[ch] = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int k = 0; k < NCH; k++) begin
        if (outValid[k] && outReady[k]) begin
          if (rdIdx[k] >= wrIdx[k]) begin
            check(1'b0, "R7/R8 unexpected word", outWord, 32'h0);
          end else begin
            check(outWord == expMem[k][rdIdx[k]], "R1-R6 word", outWord, expMem[k][rdIdx[k]]);
            check(outWord[2:0] == 3'(k), "R12 tag matches stream", {29'h0, outWord[2:0]}, k);
            rdIdx[k]++;
          end
        end
      end
    end
  end

  task automatic check_drained(input string req);
    for (int k = 0; k < NCH; k++)
      check(rdIdx[k] == wrIdx[k], req, rdIdx[k], wrIdx[k]);
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) begin wrIdx[k] = 0; rdIdx[k] = 0; end
    repeat (5) @(negedge clk);
    check(outValid == '0, "R13 reset valid", {24'h0, outValid}, 32'h0);
    check(overflowFlag == '0, "R13 reset overflow", {24'h0, overflowFlag}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == '0, "R13 after reset valid", {24'h0, outValid}, 32'h0);

    // R3 R4 R5 R6: mixed formats, channels 5-7 idle (R7)
    chanModes = {3'b000, 3'b000, 3'b000, 3'b011, 3'b111, 3'b010, 3'b001, 3'b000};
    fork
      begin
        send_frame(0, pat(0, 0, 0), pat(0, 0, 1), 1, 1);
        send_frame(0, pat(0, 1, 0), pat(0, 1, 1), 1, 1);
      end
      send_frame(1, pat(1, 0, 0), pat(1, 0, 1), 1, 1);
      send_frame(2, pat(2, 0, 0), pat(2, 0, 1), 1, 1);
      send_frame(3, pat(3, 0, 0), pat(3, 0, 1), 1, 1);
      send_frame(4, pat(4, 0, 0), pat(4, 0, 1), 1, 1);
    join
    repeat (60) @(negedge clk);
    check_drained("R7 mixed formats delivered, idle channels silent");

    // R9: all channels finish slots in the same cycle
    chanModes = '0;
    fork
      send_frame(0, pat(0, 5, 0), pat(0, 5, 1), 1, 1);
      send_frame(1, pat(1, 5, 0), pat(1, 5, 1), 1, 1);
      send_frame(2, pat(2, 5, 0), pat(2, 5, 1), 1, 1);
      send_frame(3, pat(3, 5, 0), pat(3, 5, 1), 1, 1);
      send_frame(4, pat(4, 5, 0), pat(4, 5, 1), 1, 1);
      send_frame(5, pat(5, 5, 0), pat(5, 5, 1), 1, 1);
      send_frame(6, pat(6, 5, 0), pat(6, 5, 1), 1, 1);
      send_frame(7, pat(7, 5, 0), pat(7, 5, 1), 1, 1);
    join
    repeat (60) @(negedge clk);
    check_drained("R9 simultaneous words all delivered");
    check(overflowFlag == '0, "R9 no overflow", {24'h0, overflowFlag}, 32'h0);

    // R10 R11 R12: stall everything, overrun channel 0
    chanModes = {21'h0, 3'b001};
    outReady = '0;
    for (int f = 0; f < 5; f++)
      send_frame(0, pat(0, 10 + f, 0), pat(0, 10 + f, 1), f != 4, 1);
    repeat (20) @(negedge clk);
    check(overflowFlag == 8'h01, "R11 overflow set", {24'h0, overflowFlag}, 32'h1);
    check(outValid == 8'h01, "R12 head valid on tag 0 only", {24'h0, outValid}, 32'h1);
    check(outWord == expMem[0][rdIdx[0]], "R12 head word while stalled", outWord, expMem[0][rdIdx[0]]);
    outReady = 8'h02;
    repeat (10) @(negedge clk);
    check(outWord == expMem[0][rdIdx[0]], "R12 other ready leaves head", outWord, expMem[0][rdIdx[0]]);
    check(outValid == 8'h01, "R12 head still pending", {24'h0, outValid}, 32'h1);
    outReady = '1;
    repeat (40) @(negedge clk);
    check_drained("R10 nine words survive the stall");
    check(overflowFlag == 8'h01, "R11 overflow sticky", {24'h0, overflowFlag}, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule